// File: doc/BRIEF.md
# Paged SRAM address selector

This block builds the full data-memory address for a small 8-bit processor whose SRAM is split into 256-byte pages. On each access the core supplies an 8-bit offset and an access kind: direct, indexed, stack or register-space. The block answers in the same cycle with a paged SRAM address and a select line. The page comes from one of three page pointers (current, stack, index), or is forced to page 0. The choice depends on the access kind and on a two-bit page-mode field held in a flags register. The block owns that register.

The block also saves the flags when an interrupt is taken. On the entry pulse it offers the present flags byte on a push port, and it clears the register, so the handler starts in page mode 00. On the return pulse it loads the byte that the core pops from the stack. The page pointers are not part of this save and restore. A handler that changes a pointer leaves that change in place after it returns.

Top module: `page_addr_sel`

## Requirements
- R1: After reset the flags register reads 0 and all three page pointers hold 0, so direct, indexed and stack accesses all address page 0.
- R2: The page mode is flags bits [7:6]. In mode 00, direct and indexed accesses both go to page 0.
- R3: In mode 01, direct accesses go to page 0 and indexed accesses go to the stack pointer's page.
- R4: In mode 10, direct accesses go to the current pointer's page and indexed accesses go to the index pointer's page.
- R5: In mode 11, direct accesses go to the current pointer's page and indexed accesses go to the stack pointer's page.
- R6: A stack access (access kind 2) uses the stack pointer's page in every mode.
- R7: A register-space access (access kind 3) drives the select line low and drives the page bits of the address to 0, with the offset passed through unchanged. Kinds 0, 1 and 2 drive the select line high.
- R8: During an interrupt-entry pulse, the push strobe is high and the push byte equals the flags value present in that cycle. From the next cycle the flags read 0. The push strobe is low in every other cycle.
- R9: A return pulse loads the pop byte into the flags, and the new value is visible in the next cycle.
- R10: Interrupt entry and return leave all three page pointers unchanged.
- R11: A pointer write updates only the pointer chosen by the select code (0 current, 1 stack, 2 index) and takes effect in the next cycle. Select code 3 changes nothing.
- R12: A flags write takes effect in the next cycle. An entry pulse overrides it, and so does a return pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| offset | input | 8 | Address offset within the page |
| accType | input | 2 | Access kind: 0 direct, 1 indexed, 2 stack, 3 register space |
| ptrWrEn | input | 1 | Page-pointer write strobe |
| ptrSel | input | 2 | Pointer select: 0 current, 1 stack, 2 index |
| ptrWrData | input | 3 | New page-pointer value |
| flagsWrEn | input | 1 | Flags write strobe |
| flagsWrData | input | 8 | New flags value |
| irqEnter | input | 1 | Interrupt-entry pulse |
| irqReturn | input | 1 | Interrupt-return pulse |
| popData | input | 8 | Flags byte popped from the stack on return |
| pushEn | output | 1 | Push strobe for the saved flags |
| pushData | output | 8 | Flags byte to push |
| flagsOut | output | 8 | Present flags value |
| sramAddr | output | 11 | Paged address {page, offset} |
| sramSel | output | 1 | High for SRAM accesses, low for register space |

## Verification
The assertions assume that the entry and return pulses never occur in the same cycle. They also assume that reset is held for at least one clock edge before any property is evaluated. The bench raises each pulse alone, for one cycle, and never raises both together. Pointer writes and flags writes are applied one at a time, except for the two priority cases, where a flags write deliberately coincides with a single interrupt pulse. The sweep covers every mode, access kind and pointer value under these conditions.

// File: rtl/pas_pkg.sv
package pas_pkg;
  typedef enum logic [1:0] {
    ACC_DIRECT  = 2'd0,
    ACC_INDEXED = 2'd1,
    ACC_STACK   = 2'd2,
    ACC_REG     = 2'd3
  } acc_t;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic       wrCur;
    logic       wrStk;
    logic       wrIdx;
    logic [1:0] pageMode;
    logic       useDirect;
    logic       useIndexed;
    logic       useStack;
    logic       useReg;
  } strobe_t;

  localparam int NUM_PTR = 3;
  localparam int PTR_CUR = 0;
  localparam int PTR_STK = 1;
  localparam int PTR_IDX = 2;
endpackage

// File: rtl/pas_ctrl.sv
module pas_ctrl
  import pas_pkg::*;
#(
  parameter int FLAG_W   = 8,
  parameter int MODE_LSB = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        accType,
  input  logic              ptrWrEn,
  input  logic [1:0]        ptrSel,
  input  logic              flagsWrEn,
  input  logic [FLAG_W-1:0] flagsWrData,
  input  logic              irqEnter,
  input  logic              irqReturn,
  input  logic [FLAG_W-1:0] popData,
  output logic              pushEn,
  output logic [FLAG_W-1:0] pushData,
  output logic [FLAG_W-1:0] flagsOut,
  output strobe_t           strobes
);
  logic [FLAG_W-1:0] flagsQ;

  // Entry wins over return, and return wins over a software write
  always_ff @(posedge clk) begin
    if (!rstN)          flagsQ <= '0;
    else if (irqEnter)  flagsQ <= '0;
    else if (irqReturn) flagsQ <= popData;
    else if (flagsWrEn) flagsQ <= flagsWrData;
  end

  assign flagsOut = flagsQ;
  assign pushEn   = irqEnter;
  assign pushData = flagsQ;

  always_comb begin
    strobes            = '0;
    strobes.wrCur      = ptrWrEn && (ptrSel == 2'(PTR_CUR));
    strobes.wrStk      = ptrWrEn && (ptrSel == 2'(PTR_STK));
    strobes.wrIdx      = ptrWrEn && (ptrSel == 2'(PTR_IDX));
    strobes.pageMode   = flagsQ[MODE_LSB +: 2];
    unique case (acc_t'(accType))
      ACC_DIRECT:  strobes.useDirect  = 1'b1;
      ACC_INDEXED: strobes.useIndexed = 1'b1;
      ACC_STACK:   strobes.useStack   = 1'b1;
      ACC_REG:     strobes.useReg     = 1'b1;
    endcase
  end

  // R8
  irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(irqEnter && irqReturn));
  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqEnter |=> (flagsOut == '0));
  // R9
  irq_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReturn && !irqEnter) |=> (flagsOut == $past(popData)));
  // R12
  flags_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagsWrEn && !irqEnter && !irqReturn) |=> (flagsOut == $past(flagsWrData)));
  // R12
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flagsWrEn && !irqEnter && !irqReturn) |=> $stable(flagsOut));
endmodule

// File: rtl/pas_datapath.sv
module pas_datapath
  import pas_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int OFF_W  = 8,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [PAGE_W-1:0] ptrWrData,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramSel
);
  logic [NUM_PTR-1:0] wrVec;
  logic [PAGE_W-1:0]  ptrQ [NUM_PTR];
  logic [PAGE_W-1:0]  page;

  assign wrVec = {strobes.wrIdx, strobes.wrStk, strobes.wrCur};

  for (genvar g = 0; g < NUM_PTR; g++) begin : gPtr
    always_ff @(posedge clk) begin
      if (!rstN)         ptrQ[g] <= '0;
      else if (wrVec[g]) ptrQ[g] <= ptrWrData;
    end

    // R10
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !wrVec[g] |=> $stable(ptrQ[g]));
  end

  always_comb begin
    page = '0;
    if (strobes.useStack) begin
      page = ptrQ[PTR_STK];
    end else if (strobes.useDirect) begin
      page = strobes.pageMode[1] ? ptrQ[PTR_CUR] : '0;
    end else if (strobes.useIndexed) begin
      unique case (strobes.pageMode)
        2'b00: page = '0;
        2'b01: page = ptrQ[PTR_STK];
        2'b10: page = ptrQ[PTR_IDX];
        2'b11: page = ptrQ[PTR_STK];
      endcase
    end
  end

  assign sramAddr = {page, offset};
  assign sramSel  = !strobes.useReg;

  // R6
  stack_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.useStack |-> (sramAddr[ADDR_W-1:OFF_W] == ptrQ[PTR_STK]));
  // R7
  reg_unpaged_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.useReg |-> (!sramSel && sramAddr[ADDR_W-1:OFF_W] == '0));
  // R2
  mode_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strobes.pageMode == 2'b00) && (strobes.useDirect || strobes.useIndexed))
      |-> (sramAddr[ADDR_W-1:OFF_W] == '0));
  // R7
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    sramAddr[OFF_W-1:0] == offset);
endmodule

// File: rtl/page_addr_sel.sv
module page_addr_sel
  import pas_pkg::*;
#(
  parameter int PAGE_W   = 3,
  parameter int OFF_W    = 8,
  parameter int FLAG_W   = 8,
  parameter int MODE_LSB = 6,
  localparam int ADDR_W  = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        accType,
  input  logic              ptrWrEn,
  input  logic [1:0]        ptrSel,
  input  logic [PAGE_W-1:0] ptrWrData,
  input  logic              flagsWrEn,
  input  logic [FLAG_W-1:0] flagsWrData,
  input  logic              irqEnter,
  input  logic              irqReturn,
  input  logic [FLAG_W-1:0] popData,
  output logic              pushEn,
  output logic [FLAG_W-1:0] pushData,
  output logic [FLAG_W-1:0] flagsOut,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramSel
);
  strobe_t strobes;

  pas_ctrl #(.FLAG_W(FLAG_W), .MODE_LSB(MODE_LSB)) u_ctrl (
    .clk(clk), .rstN(rstN), .accType(accType),
    .ptrWrEn(ptrWrEn), .ptrSel(ptrSel),
    .flagsWrEn(flagsWrEn), .flagsWrData(flagsWrData),
    .irqEnter(irqEnter), .irqReturn(irqReturn), .popData(popData),
    .pushEn(pushEn), .pushData(pushData), .flagsOut(flagsOut),
    .strobes(strobes)
  );

  pas_datapath #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .ptrWrData(ptrWrData), .offset(offset),
    .sramAddr(sramAddr), .sramSel(sramSel)
  );
endmodule

// File: tb/page_addr_sel_bench.sv
module page_addr_sel_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  offset = '0;
  logic [1:0]  accType = '0;
  logic        ptrWrEn = 1'b0;
  logic [1:0]  ptrSel = '0;
  logic [2:0]  ptrWrData = '0;
  logic        flagsWrEn = 1'b0;
  logic [7:0]  flagsWrData = '0;
  logic        irqEnter = 1'b0;
  logic        irqReturn = 1'b0;
  logic [7:0]  popData = '0;
  logic        pushEn;
  logic [7:0]  pushData;
  logic [7:0]  flagsOut;
  logic [10:0] sramAddr;
  logic        sramSel;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;  // 50 MHz

  page_addr_sel u_page_addr_sel (
    .clk(clk), .rstN(rstN), .offset(offset), .accType(accType),
    .ptrWrEn(ptrWrEn), .ptrSel(ptrSel), .ptrWrData(ptrWrData),
    .flagsWrEn(flagsWrEn), .flagsWrData(flagsWrData),
    .irqEnter(irqEnter), .irqReturn(irqReturn), .popData(popData),
    .pushEn(pushEn), .pushData(pushData), .flagsOut(flagsOut),
    .sramAddr(sramAddr), .sramSel(sramSel)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expPage(int mode, int acc, int c, int s, int i);
    if (acc == 2) return s;
    if (acc == 3) return 0;
    if (acc == 0) return (mode >= 2) ? c : 0;
    case (mode)
      0: return 0;
      1: return s;
      2: return i;
      default: return s;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writePtr(input int sel, input int val);
    ptrWrEn = 1'b1; ptrSel = 2'(sel); ptrWrData = 3'(val);
    tick();
    ptrWrEn = 1'b0;
  endtask

  task automatic writeFlags(input int val);
    flagsWrEn = 1'b1; flagsWrData = 8'(val);
    tick();
    flagsWrEn = 1'b0;
  endtask

  task automatic probe(input string req, input int acc, input int off, input int page);
    accType = 2'(acc); offset = 8'(off);
    #2;
    check(req, int'(sramAddr), page * 256 + off);
    check(req, int'(sramSel), (acc != 3) ? 1 : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1", int'(flagsOut), 0);
    probe("R1", 0, 8'h12, 0);
    probe("R1", 1, 8'h34, 0);
    probe("R1", 2, 8'h56, 0);

    // Sweep every mode, pointer set and access kind (R2..R7, R11, R12)
    for (int mode = 0; mode < 4; mode++) begin
      for (int v = 0; v < 8; v++) begin
        int s, i;
        s = (v + 3) % 8;
        i = (v + 5) % 8;
        writePtr(0, v);
        writePtr(1, s);
        writePtr(2, i);
        writeFlags((mode << 6) | v);
        check("R12", int'(flagsOut), (mode << 6) | v);
        for (int acc = 0; acc < 4; acc++) begin
          if (acc == 2)      tag = "R6";
          else if (acc == 3) tag = "R7";
          else if (mode == 0) tag = "R2";
          else if (mode == 1) tag = "R3";
          else if (mode == 2) tag = "R4";
          else               tag = "R5";
          probe(tag, acc, (v * 37 + acc * 11) % 256, expPage(mode, acc, v, s, i));
        end
      end
    end

    // R11: select code 3 changes nothing; write lands one cycle later
    writePtr(0, 2); writePtr(1, 4); writePtr(2, 6);
    writeFlags(8'h80);
    writePtr(3, 7);
    probe("R11", 0, 8'h01, 2);
    probe("R11", 1, 8'h02, 6);
    probe("R11", 2, 8'h03, 4);
    ptrWrEn = 1'b1; ptrSel = 2'd0; ptrWrData = 3'd5;
    probe("R11", 0, 8'h04, 2);
    tick();
    ptrWrEn = 1'b0;
    probe("R11", 0, 8'h04, 5);
    probe("R11", 1, 8'h05, 6);

    // Interrupt entry (R8)
    writeFlags(8'hC5);
    #2 check("R8", int'(pushEn), 0);
    irqEnter = 1'b1;
    #2;
    check("R8", int'(pushEn), 1);
    check("R8", int'(pushData), 8'hC5);
    tick();
    irqEnter = 1'b0;
    check("R8", int'(flagsOut), 0);
    probe("R8", 1, 8'h10, 0);
    check("R8", int'(pushEn), 0);
    // Handler changes mode and stack pointer
    writeFlags(8'h81);
    writePtr(1, 1);
    // Return (R9, R10)
    irqReturn = 1'b1; popData = 8'hC5;
    tick();
    irqReturn = 1'b0;
    check("R9", int'(flagsOut), 8'hC5);
    probe("R10", 1, 8'h20, 1);
    probe("R10", 0, 8'h21, 5);
    probe("R10", 2, 8'h22, 1);
    writeFlags(8'h80);
    probe("R10", 1, 8'h23, 6);

    // R12 priorities
    flagsWrEn = 1'b1; flagsWrData = 8'h40; irqEnter = 1'b1;
    tick();
    flagsWrEn = 1'b0; irqEnter = 1'b0;
    check("R12", int'(flagsOut), 0);
    flagsWrEn = 1'b1; flagsWrData = 8'h40; irqReturn = 1'b1; popData = 8'h80;
    tick();
    flagsWrEn = 1'b0; irqReturn = 1'b0;
    check("R12", int'(flagsOut), 8'h80);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule